// File: doc/BRIEF.md
# Serial Configuration Write Port with Addressed Latches

This block takes configuration words over a three-wire, write-only serial link (a serial clock, a data line and a load strobe). It moves them into one of four parallel configuration latches. Bits are shifted into a 24-bit shift register most significant bit first, one bit on each rising edge of the serial clock. When the load strobe rises, the two bits shifted in last act as a latch address. The remaining 22 bits are copied into the latch that address selects.

The serial pins are asynchronous to the block's own clock. Each is passed through a two-flop synchronizer, and edges are detected in the system clock domain. The system clock must therefore run at least four times faster than the serial clock. Every latch also has an update pulse that lasts one system clock cycle, so that the logic downstream knows when a new value has arrived.

Top module: `ser_cfg_port`

## Requirements
- R1: After a synchronous active-low reset, all four latches read zero and every update pulse is low.
- R2: A bit is taken from the data line on each rising edge of the serial clock and enters at the least significant end of the shift register. The word is therefore sent most significant bit first. Falling edges of the serial clock shift nothing.
- R3: On a rising edge of the load strobe, the two bits shifted in last (word bits 1:0) select the latch: 00 selects latch 0, 01 selects latch 1, 10 selects latch 2 and 11 selects latch 3. Word bits 23:2 are stored in latch bits 21:0.
- R4: Rising edges of the serial clock that arrive while the load strobe is high are ignored. A later load with no new bits reloads the unchanged word.
- R5: A load changes only the selected latch. The other three latches keep their values.
- R6: update bit k is high for exactly one system clock cycle per load into latch k. It is high in the first cycle in which the new value is visible, and at most one update bit is high at a time.
- R7: When more than 24 bits are shifted in before a load, only the last 24 bits count.
- R8: The new latch value is visible at the outputs no later than the fourth system clock edge after the load strobe goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data, asynchronous to clk |
| ld_i | input | 1 | Load strobe, asynchronous to clk |
| cfg_o | output | 4x22 | Contents of the four latches; entry k is latch k |
| upd_o | output | 4 | One-cycle update pulse per latch |

## Verification
The bench sends words to every address, including all-ones and alternating payloads, and checks that no other latch moves. A design that decodes the address badly, or that writes more than one latch, fails there. It sends words with extra leading bits; a design that keeps stale bits stores a wrong payload. It toggles the serial clock while the strobe is high and then reloads without new bits; a design that shifts during the strobe reloads a shifted word. It also measures the latency from the strobe to the output and checks that each update pulse lasts one cycle; a design whose edge detector is level-sensitive produces stretched pulses.

// File: rtl/cfgser_pkg.sv
// Shared constants for the serial configuration port.
package cfgser_pkg;
    parameter int WORD_W_DEF      = 24;  // bits per serial word
    parameter int SEL_W_DEF       = 2;   // trailing address bits
    parameter int SYNC_STAGES_DEF = 2;   // synchronizer depth
endpackage

// File: rtl/cfgser_sync.sv
// Synchronizes the three serial pins into the system clock domain and
// detects rising edges of the serial clock and the load strobe.
// Assumes clk runs at least 4x faster than the serial clock.
module cfgser_sync #(
    parameter int STAGES = cfgser_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic ld_i,
    output logic sdi_lvl,
    output logic ld_lvl,
    output logic sck_rise,
    output logic ld_rise
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] synced;
    logic            sck_prev;
    logic            ld_prev;

    assign pins = {ld_i, sdi_i, sck_i};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Shift the pin through a chain of STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pins[p]};
        end
        assign synced[p] = chain[STAGES-1];
    end

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            ld_prev  <= 1'b0;
        end else begin
            sck_prev <= synced[0];
            ld_prev  <= synced[2];
        end
    end

    assign sdi_lvl  = synced[1];
    assign ld_lvl   = synced[2];
    assign sck_rise = synced[0] & ~sck_prev;
    assign ld_rise  = synced[2] & ~ld_prev;

    // R6: a strobe edge cannot be reported in two cycles in a row
    a_r6_ld_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rise |=> !ld_rise);
endmodule

// File: rtl/cfgser_shift.sv
// Serial-in shift register. It takes one data bit into the LSB on each
// detected serial clock rise unless the load strobe is high.
module cfgser_shift #(
    parameter int WORD_W = cfgser_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sdi_lvl,
    input  logic              ld_lvl,
    output logic [WORD_W-1:0] word
);
    // Shift on a serial clock rise while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                     word <= '0;
        else if (sck_rise && !ld_lvl)   word <= {word[WORD_W-2:0], sdi_lvl};
    end

    // R4: no shifting while the load strobe is high
    a_r4_hold_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lvl |=> $stable(word));
    // R2: the register moves only on a serial clock rise
    a_r2_shift_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(word));
endmodule

// File: rtl/cfgser_bank.sv
// Bank of addressed configuration latches. On load, the payload (upper
// bits of the word) goes to the latch named by the low SEL_W bits, and
// that latch's update bit pulses for one cycle.
module cfgser_bank #(
    parameter int WORD_W = cfgser_pkg::WORD_W_DEF,
    parameter int SEL_W  = cfgser_pkg::SEL_W_DEF,
    localparam int NLAT  = 1 << SEL_W,
    localparam int PAY_W = WORD_W - SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [WORD_W-1:0]           word,
    output logic [NLAT-1:0][PAY_W-1:0]  lat,
    output logic [NLAT-1:0]             upd
);
    logic [SEL_W-1:0] sel;
    assign sel = word[SEL_W-1:0];

    for (genvar k = 0; k < NLAT; k++) begin : g_lat
        logic hit;
        assign hit = load && (sel == SEL_W'(k));
        // Capture the payload and pulse the update bit on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat[k] <= '0;
                upd[k] <= 1'b0;
            end else begin
                upd[k] <= hit;
                if (hit) lat[k] <= word[WORD_W-1:SEL_W];
            end
        end
    end

    // R6: at most one update bit at a time
    a_r6_upd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd));
    // R5: the latches hold when no load occurs
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lat));
    // R6: an update pulse lasts one cycle
    a_r6_upd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (upd != '0) |=> (upd == '0));
endmodule

// File: rtl/ser_cfg_port.sv
// Top of the serial configuration write port: synchronizer, shift
// register and latch bank. Write-only; the latches reset to zero.
module ser_cfg_port #(
    parameter int WORD_W      = cfgser_pkg::WORD_W_DEF,
    parameter int SEL_W       = cfgser_pkg::SEL_W_DEF,
    parameter int SYNC_STAGES = cfgser_pkg::SYNC_STAGES_DEF,
    localparam int NLAT       = 1 << SEL_W,
    localparam int PAY_W      = WORD_W - SEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck_i,
    input  logic                       sdi_i,
    input  logic                       ld_i,
    output logic [NLAT-1:0][PAY_W-1:0] cfg_o,
    output logic [NLAT-1:0]            upd_o
);
    logic              sdi_lvl;
    logic              ld_lvl;
    logic              sck_rise;
    logic              ld_rise;
    logic [WORD_W-1:0] word;

    cfgser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi_i(sdi_i), .ld_i(ld_i),
        .sdi_lvl(sdi_lvl), .ld_lvl(ld_lvl), .sck_rise(sck_rise), .ld_rise(ld_rise)
    );

    cfgser_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sdi_lvl(sdi_lvl),
        .ld_lvl(ld_lvl), .word(word)
    );

    cfgser_bank #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(ld_rise), .word(word),
        .lat(cfg_o), .upd(upd_o)
    );

    // R1: no update pulse in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (upd_o == '0));
endmodule

// File: tb/tb_ser_cfg_port.sv
// Scoreboard bench: the driver queues each expected word and the monitor
// checks every update pulse against the queue and a shadow model.
module tb_ser_cfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, ld = 1'b0;
    logic [3:0][21:0] cfg;
    logic [3:0]       upd;

    int total = 0;
    int bad = 0;
    logic [23:0] exp_q[$];
    logic [21:0] model[4];
    logic [3:0]  upd_prev = '0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    ser_cfg_port dut (.clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi),
                      .ld_i(ld), .cfg_o(cfg), .upd_o(upd));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b; wait_n(4);
        sck = 1'b1; wait_n(4);
        sck = 1'b0; wait_n(2);
    endtask

    task automatic pulse_ld();
        ld = 1'b1; wait_n(6);
        ld = 1'b0; wait_n(4);
    endtask

    // Shift junk leading bits, then the word MSB first, then load.
    task automatic send_word(input logic [23:0] w, input int lead);
        for (int i = 0; i < lead; i++) send_bit(i[0]);
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
        exp_q.push_back(w);
        pulse_ld();
    endtask

    // Monitor: pop and compare on every update pulse.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int k = 0; k < 4; k++) begin
                if (upd[k] && upd_prev[k])
                    chk(1'b0, "R6 pulse longer than one cycle", 32'(upd), 32'(0));
                if (upd[k] && !upd_prev[k]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected update", 32'(upd), 32'(0));
                    end else begin
                        logic [23:0] w;
                        w = exp_q.pop_front();
                        chk(k == int'(w[1:0]), "R3 latch select", 32'(k), 32'(w[1:0]));
                        chk(cfg[k] == w[23:2], "R3 payload", 32'(cfg[k]), 32'(w[23:2]));
                        for (int j = 0; j < 4; j++)
                            if (j != k)
                                chk(cfg[j] == model[j], "R5 other latch", 32'(cfg[j]), 32'(model[j]));
                        model[k] = w[23:2];
                    end
                end
            end
            chk($onehot0(upd), "R6 onehot", 32'(upd), 32'(0));
            upd_prev = upd;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        for (int k = 0; k < 4; k++) chk(cfg[k] == '0, "R1 latch reset", 32'(cfg[k]), 32'(0));
        chk(upd == '0, "R1 update reset", 32'(upd), 32'(0));
        mon_on = 1'b1;

        // R2/R3: every address, varied payloads
        send_word(24'hABCDE4, 0);
        send_word(24'h123455, 0);
        send_word(24'hFFFFFE, 0);
        send_word(24'hAAAAA3, 0);
        send_word(24'h000001, 0);   // clears latch 1 back to zero, R5 others kept
        send_word(24'h555557, 0);

        // R7: extra leading bits are dropped
        send_word(24'h3C3C38, 7);

        // R4: serial clock edges while strobe high are ignored; reload same word
        for (int i = 23; i >= 0; i--) send_bit(24'h0F0F06 >> i);
        exp_q.push_back(24'h0F0F06);
        ld = 1'b1; wait_n(6);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        ld = 1'b0; wait_n(4);
        exp_q.push_back(24'h0F0F06);  // R4 reload must give the same word
        pulse_ld();

        // R8: latency from the strobe to the output
        for (int i = 23; i >= 0; i--) send_bit(24'h765430 >> i);
        exp_q.push_back(24'h765430);
        @(negedge clk) ld = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(cfg[0] == 22'(24'h765430 >> 2), "R8 latency", 32'(cfg[0]), 32'(24'h765430 >> 2));
        wait_n(5);
        ld = 1'b0;
        wait_n(6);

        chk(exp_q.size() == 0, "R6 all loads produced a pulse", 32'(exp_q.size()), 32'(0));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule